// File: doc/BRIEF.md
# GPIO Port with Peripheral Direction Override

This block controls an eight-pin general-purpose I/O port. Software sets each pin's direction through a direction register. It writes output values into a port data latch and reads pin state back over a small synchronous register bus. Direction bit 1 makes a pin an output and 0 makes it an input. All direction bits come out of reset at 0.

Four paired serial channels and one extra serial transmit/receive function can take over pins. Enabling a channel forces its receive pin to input and its transmit pin to output, and the peripheral then supplies the transmit value. The stored direction and data bits stay as software last wrote them. When the channel is disabled, the pin follows its register bits again.

Pad input values pass through a two-stage synchronizer on the bus clock before any read path sees them. After a direction change, a read can therefore take up to two bus cycles to show the settled pad value.

Top module: `gpioOverridePort`

## Requirements
- R1: After reset the direction register and the port data latch read 0, and every pad output enable is 0.
- R2: Writing address 1 loads the direction register, and reading address 1 returns it at any time. An active peripheral override never changes the stored direction bits.
- R3: A pin that no peripheral claims has its output enable equal to its direction bit. Its pad output value equals its port data latch bit.
- R4: While channel k (k = 0..3) is enabled, pin 2k+1 is an output driven with that channel's transmit value and pin 2k is an input, whatever the direction register holds.
- R5: While the extra serial function is enabled and channel 3 is disabled, pin 7 is an output driven with the serial transmit value and pin 6 is an input. When channel 3 is enabled, it takes pins 6 and 7 and the serial function is ignored.
- R6: When a peripheral is disabled, its pins return at once to the direction and data held in the registers.
- R7: The synchronized input value (read at address 2 and presented on `syncIn`) equals the pad input sampled at the clock edge one cycle before the previous edge, giving two stages of delay. The synchronizer resets to 0.
- R8: Reading address 0 returns, bit by bit, the data latch for pins whose effective direction is output and the synchronized pad value for pins whose effective direction is input.
- R9: Writes to addresses 2 and 3 change no state. Reading address 3 returns 0. Read data is 0 when no read is selected.
- R10: Writing address 0 loads the port data latch even while its pins are inputs. The stored value drives the pad once the pins turn into outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address: 0 data, 1 direction, 2 synchronized input, 3 unused |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Combinational read data |
| chanEn | input | 4 | Enable of each paired serial channel |
| chanTx | input | 4 | Transmit value of each channel |
| serEn | input | 1 | Enable of the extra serial function on pins 6/7 |
| serTx | input | 1 | Transmit value of the extra serial function |
| padIn | input | 8 | Raw pad input levels |
| padOe | output | 8 | Pad output enables |
| padOut | output | 8 | Pad output values |
| syncIn | output | 8 | Synchronized pad values for peripherals |

## Verification
The synchronizer assertion assumes that the pad inputs are sampled cleanly at each edge. The bench therefore changes `padIn` only at the falling edge, with no asynchronous glitches. The override assertions assume that channel enables and transmit values are stable across each rising edge, and the stimulus updates every input only at the falling edge. The bus is assumed to issue at most one access per cycle, with `busWrite` and `busAddr` meaningful only while `busSel` is high. Idle cycles in the stimulus drive `busSel` low.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_IN   = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    regSel_e rdSel;
  } portStrobe_t;
endpackage

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
#(
  parameter int CHAN_COUNT = 4,
  parameter int SER_RX_PIN = 6,
  parameter int SER_TX_PIN = 7,
  localparam int PIN_COUNT = 2 * CHAN_COUNT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [1:0]            busAddr,
  input  logic [CHAN_COUNT-1:0] chanEn,
  input  logic [CHAN_COUNT-1:0] chanTx,
  input  logic                  serEn,
  input  logic                  serTx,
  output portStrobe_t           strobe,
  output logic [PIN_COUNT-1:0]  claimMask,
  output logic [PIN_COUNT-1:0]  driveMask,
  output logic [PIN_COUNT-1:0]  periphData
);
  localparam int RX_CHAN = SER_RX_PIN / 2;
  localparam int TX_CHAN = SER_TX_PIN / 2;

  logic [PIN_COUNT-1:0] chanClaim;
  logic [PIN_COUNT-1:0] chanDrive;
  logic [PIN_COUNT-1:0] chanData;
  logic                 serLive;

  always_comb begin
    strobe.wrData = busSel && busWrite && (busAddr == SEL_DATA);
    strobe.wrDir  = busSel && busWrite && (busAddr == SEL_DIR);
    strobe.rdSel  = (busSel && !busWrite) ? regSel_e'(busAddr) : SEL_NONE;
  end

  for (genvar k = 0; k < CHAN_COUNT; k++) begin : g_chan
    assign chanClaim[2*k]   = chanEn[k];
    assign chanClaim[2*k+1] = chanEn[k];
    assign chanDrive[2*k]   = 1'b0;
    assign chanDrive[2*k+1] = chanEn[k];
    assign chanData[2*k]    = 1'b0;
    assign chanData[2*k+1]  = chanTx[k];
  end

  // The channel owning the shared pins has priority over the serial function
  assign serLive = serEn && !chanEn[RX_CHAN] && !chanEn[TX_CHAN];

  always_comb begin
    claimMask  = chanClaim;
    driveMask  = chanDrive;
    periphData = chanData;
    if (serLive) begin
      claimMask[SER_RX_PIN]  = 1'b1;
      claimMask[SER_TX_PIN]  = 1'b1;
      driveMask[SER_TX_PIN]  = 1'b1;
      periphData[SER_TX_PIN] = serTx;
    end
  end

  // R9
  unusedWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr[1]) |-> !(strobe.wrData || strobe.wrDir));
endmodule

// File: rtl/gpioPortDatapath.sv
module gpioPortDatapath
  import gpioPortPkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobe_t          strobe,
  input  logic [PIN_COUNT-1:0] wData,
  input  logic [PIN_COUNT-1:0] claimMask,
  input  logic [PIN_COUNT-1:0] driveMask,
  input  logic [PIN_COUNT-1:0] periphData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rData,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] syncIn
);
  logic [PIN_COUNT-1:0] portReg;
  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] syncA;
  logic [PIN_COUNT-1:0] syncB;
  logic [1:0]           syncWarm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portReg <= '0;
      dirReg  <= '0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      if (strobe.wrData) portReg <= wData;
      if (strobe.wrDir)  dirReg  <= wData;
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign padOe  = driveMask | (~claimMask & dirReg);
  assign padOut = (driveMask & periphData) | (~driveMask & portReg);
  assign syncIn = syncB;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DATA: rData = (padOe & portReg) | (~padOe & syncB);
      SEL_DIR:  rData = dirReg;
      SEL_IN:   rData = syncB;
      default:  rData = '0;
    endcase
  end

  // Cycle counter for the synchronizer check window only
  always_ff @(posedge clk) begin
    if (!rstN) syncWarm <= 2'd0;
    else if (syncWarm != 2'd2) syncWarm <= syncWarm + 2'd1;
  end

  // R2
  dirHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDir |=> $stable(dirReg));

  // R7
  syncDelay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncWarm == 2'd2) |-> (syncIn == $past(padIn, 2)));
endmodule

// File: rtl/gpioOverridePort.sv
module gpioOverridePort
  import gpioPortPkg::*;
#(
  parameter int CHAN_COUNT = 4,
  parameter int SER_RX_PIN = 6,
  parameter int SER_TX_PIN = 7,
  localparam int PIN_COUNT = 2 * CHAN_COUNT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [1:0]            busAddr,
  input  logic [PIN_COUNT-1:0]  busWData,
  output logic [PIN_COUNT-1:0]  busRData,
  input  logic [CHAN_COUNT-1:0] chanEn,
  input  logic [CHAN_COUNT-1:0] chanTx,
  input  logic                  serEn,
  input  logic                  serTx,
  input  logic [PIN_COUNT-1:0]  padIn,
  output logic [PIN_COUNT-1:0]  padOe,
  output logic [PIN_COUNT-1:0]  padOut,
  output logic [PIN_COUNT-1:0]  syncIn
);
  portStrobe_t          strobe;
  logic [PIN_COUNT-1:0] claimMask;
  logic [PIN_COUNT-1:0] driveMask;
  logic [PIN_COUNT-1:0] periphData;

  gpioPortCtrl #(
    .CHAN_COUNT(CHAN_COUNT), .SER_RX_PIN(SER_RX_PIN), .SER_TX_PIN(SER_TX_PIN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .chanEn(chanEn), .chanTx(chanTx), .serEn(serEn),
    .serTx(serTx), .strobe(strobe), .claimMask(claimMask),
    .driveMask(driveMask), .periphData(periphData)
  );

  gpioPortDatapath #(.PIN_COUNT(PIN_COUNT)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wData(busWData),
    .claimMask(claimMask), .driveMask(driveMask), .periphData(periphData),
    .padIn(padIn), .rData(busRData), .padOe(padOe), .padOut(padOut),
    .syncIn(syncIn)
  );

  for (genvar k = 0; k < CHAN_COUNT; k++) begin : g_chk
    // R4
    chanOverride_chk: assert property (@(posedge clk) disable iff (!rstN)
      chanEn[k] |-> (padOe[2*k+1] && !padOe[2*k] && (padOut[2*k+1] == chanTx[k])));
  end

  // R5
  serOverride_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serEn && !chanEn[SER_TX_PIN/2]) |->
      (padOe[SER_TX_PIN] && !padOe[SER_RX_PIN] && (padOut[SER_TX_PIN] == serTx)));
endmodule

// File: tb/test_gpioOverridePort.sv
module test_gpioOverridePort;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWrite = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWData = 8'h00;
  logic [7:0] busRData;
  logic [3:0] chanEn = 4'h0, chanTx = 4'h0;
  logic       serEn = 1'b0, serTx = 1'b0;
  logic [7:0] padIn = 8'h00;
  logic [7:0] padOe, padOut, syncIn;

  int total = 0, failed = 0;
  bit done = 0;
  string phase = "R1";

  logic [7:0] mDir = 8'h00, mData = 8'h00, mS1 = 8'h00, mS2 = 8'h00;

  always #2 clk = ~clk;

  gpioOverridePort i_gpioOverridePort (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .chanEn(chanEn), .chanTx(chanTx), .serEn(serEn), .serTx(serTx),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .syncIn(syncIn)
  );

  task automatic chk(string name, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", phase, name, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [7:0] eOe, eOut, eRd;
    for (int p = 0; p < 8; p++) begin
      logic claim, drv, dat;
      claim = chanEn[p/2];
      drv   = claim && (p % 2 == 1);
      dat   = chanTx[p/2];
      if (serEn && !chanEn[3] && (p == 6 || p == 7)) begin
        claim = 1'b1; drv = (p == 7); dat = serTx;
      end
      eOe[p]  = claim ? drv : mDir[p];
      eOut[p] = drv ? dat : mData[p];
    end
    eRd = 8'h00;
    if (busSel && !busWrite) begin
      case (busAddr)
        2'd0: eRd = (eOe & mData) | (~eOe & mS2);
        2'd1: eRd = mDir;
        2'd2: eRd = mS2;
        default: eRd = 8'h00;
      endcase
    end
    chk("padOe", padOe, eOe);
    chk("padOut", padOut, eOut);
    chk("busRData", busRData, eRd);
    chk("syncIn", syncIn, mS2);
  endtask

  task automatic step(logic s, logic w, logic [1:0] a, logic [7:0] d);
    busSel = s; busWrite = w; busAddr = a; busWData = d;
    @(posedge clk);
    if (!rstN) begin
      mDir = 0; mData = 0; mS1 = 0; mS2 = 0;
    end else begin
      if (s && w && a == 2'd0) mData = d;
      if (s && w && a == 2'd1) mDir = d;
      mS2 = mS1;
      mS1 = padIn;
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    phase = "R1";
    padIn = 8'hC3;
    step(1'b0, 1'b0, 2'd0, 8'h00);
    step(1'b0, 1'b0, 2'd0, 8'h00);
    rstN = 1'b1;
    step(1'b1, 1'b0, 2'd1, 8'h00);
    chk("dir after reset R1", busRData, 8'h00);
    step(1'b1, 1'b0, 2'd0, 8'h00);

    phase = "R3";
    step(1'b1, 1'b1, 2'd1, 8'h0F);
    step(1'b1, 1'b1, 2'd0, 8'h5A);
    chk("oe follows dir R3", padOe, 8'h0F);
    step(1'b1, 1'b0, 2'd0, 8'h00);
    idle(2);

    phase = "R10";
    step(1'b1, 1'b1, 2'd1, 8'h00);
    step(1'b1, 1'b1, 2'd0, 8'h3C);
    step(1'b1, 1'b1, 2'd1, 8'hFF);
    chk("latched data R10", padOut, 8'h3C);
    step(1'b1, 1'b0, 2'd0, 8'h00);

    phase = "R7";
    for (int i = 0; i < 12; i++) begin
      padIn = 8'(i * 37 + 5);
      step(1'b1, 1'b0, 2'd2, 8'h00);
    end

    phase = "R8";
    step(1'b1, 1'b1, 2'd1, 8'h33);
    for (int i = 0; i < 8; i++) begin
      padIn = 8'(i * 91 + 17);
      step(1'b1, 1'b0, 2'd0, 8'h00);
    end

    phase = "R4";
    step(1'b1, 1'b1, 2'd1, 8'h55);
    for (int i = 0; i < 16; i++) begin
      chanEn = 4'(i);
      chanTx = 4'(~i);
      step(1'b1, 1'b0, 2'd0, 8'h00);
    end

    phase = "R2";
    chanEn = 4'hF;
    step(1'b1, 1'b1, 2'd1, 8'h96);
    step(1'b1, 1'b0, 2'd1, 8'h00);
    chk("dir kept under override R2", busRData, 8'h96);

    phase = "R6";
    chanEn = 4'h0;
    step(1'b1, 1'b0, 2'd0, 8'h00);
    chk("released pins R6", padOe, 8'h96);

    phase = "R5";
    serEn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      serTx = i[0];
      chanEn = {i[2], 3'b000};
      chanTx = {i[1], 3'b000};
      step(1'b1, 1'b0, 2'd0, 8'h00);
    end
    serEn = 1'b0; chanEn = 4'h0;

    phase = "R9";
    step(1'b1, 1'b1, 2'd2, 8'hA1);
    step(1'b1, 1'b1, 2'd3, 8'hB2);
    step(1'b1, 1'b0, 2'd3, 8'h00);
    chk("addr3 read R9", busRData, 8'h00);
    step(1'b1, 1'b0, 2'd1, 8'h00);
    idle(1);

    phase = "R3";
    for (int i = 0; i < 300; i++) begin
      chanEn = 4'($urandom); chanTx = 4'($urandom);
      serEn = 1'($urandom); serTx = 1'($urandom);
      padIn = 8'($urandom);
      step(1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule